// File: doc/BRIEF.md
# HDLC Receive Status Latch

This block gathers the conditions reported by an HDLC receive controller and its receive FIFO into one 8-bit sticky status byte. The receiver sends single-cycle event pulses: overrun, opening byte at the FIFO head, packet start, packet end, CRC error and abort. The FIFO supplies two real-time levels: above high watermark and not empty. Each condition sets its own status bit. The bit then stays set until software writes a 1 to that bit position.

An 8-bit mask register sits next to the status byte. The interrupt request is raised whenever a status bit and the mask bit in the same position are both 1. The packet-end bit collects several causes into one flag: a normal end, a CRC error, an abort and an overrun. The two FIFO bits react only to a rising edge of their level. A level that stays high therefore cannot set its bit again after software has cleared it.

Top module: `hdlc_rx_status_latch`

## Requirements
- R1: After reset the status byte reads 0x00. Status bits 7 and 6 always read 0, whatever events occur and whatever is written.
- R2: An overrun pulse sets status bit 5. Because an overrun is also a packet fault, the same pulse sets bit 3.
- R3: An opening-byte pulse, which means the next FIFO byte starts a message, sets status bit 4.
- R4: Status bit 3 (packet end) sets on any one of these pulses: packet end, CRC error, abort or overrun.
- R5: A packet-start pulse sets status bit 2.
- R6: Status bit 1 sets only when the above-watermark level changes from 0 to 1. A level that stays high does not set the bit again after it has been cleared. The stored previous level resets to 0.
- R7: Status bit 0 sets only when the not-empty level changes from 0 to 1. It follows the same rules as bit 1.
- R8: A status write clears each bit whose write-data bit is 1. Bits whose write-data bit is 0 are left unchanged.
- R9: If a set condition and a write-1 clear reach the same bit in the same cycle, the bit ends up set.
- R10: The mask register resets to 0x00. It loads all 8 bits on a mask write and reads back through `mask_q` after the clock edge of the write.
- R11: `irq` is 1 exactly when some bit position has both its status bit and its mask bit at 1. A mask write changes `irq` only after the clock edge that takes the write.
- R12: A status bit that is set keeps its value over idle cycles until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_overrun | input | 1 | Pulse: reception ended because the FIFO was full |
| ev_open_byte | input | 1 | Pulse: the next FIFO byte is the first byte of a message |
| ev_pkt_start | input | 1 | Pulse: opening byte detected |
| ev_pkt_end | input | 1 | Pulse: valid message end after the CRC check |
| ev_crc_err | input | 1 | Pulse: CRC check failed |
| ev_abort | input | 1 | Pulse: message aborted |
| lvl_above_hwm | input | 1 | Level: FIFO fill is above the high watermark |
| lvl_not_empty | input | 1 | Level: FIFO holds at least one byte |
| wr_status_en | input | 1 | Status write strobe (write-1-to-clear) |
| wr_status_data | input | 8 | Status clear pattern |
| wr_mask_en | input | 1 | Mask write strobe |
| wr_mask_data | input | 8 | New mask value |
| status_q | output | 8 | Latched status byte |
| mask_q | output | 8 | Mask register contents |
| irq | output | 1 | Interrupt request |

## Verification
Each event pulse is applied on its own. The resulting status byte shows that every source sets exactly its own bit, and that the overrun and the three fault or end causes all reach the shared packet-end bit. The level inputs go through three patterns: a rise, a clear while the level stays high, and a fall followed by a second rise. These separate true edge detection from level sensitivity. Clears with mixed write-data patterns check that clearing acts bit by bit. Writes that land in the same cycle as a set check the set-wins priority. Mask patterns that either cover or miss the pending bit, sampled before and after the clock edge, check the one-cycle timing of `irq`.

// File: rtl/hdlc_rxs_pkg.sv
package hdlc_rxs_pkg;
   localparam int unsigned STAT_W = 8;
   localparam int unsigned N_USED = 6;
   localparam int unsigned N_LVL  = 2;
   // bit positions inside the status byte
   localparam int unsigned B_NE   = 0;
   localparam int unsigned B_HWM  = 1;
   localparam int unsigned B_PS   = 2;
   localparam int unsigned B_PE   = 3;
   localparam int unsigned B_OB   = 4;
   localparam int unsigned B_OVR  = 5;
   // positions inside the level vector
   localparam int unsigned L_NE   = 0;
   localparam int unsigned L_HWM  = 1;
endpackage

// File: rtl/hdlc_rxs_rise_det.sv
module hdlc_rxs_rise_det #(
   parameter int unsigned W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   output logic [W-1:0] rise
);
   if (W < 1) begin : g_bad_w
      $error("hdlc_rxs_rise_det: W must be at least 1");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic prev_q;
      always_ff @(posedge clk) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= lvl[i];
      end
      assign rise[i] = lvl[i] & ~prev_q;
   end
endmodule

// File: rtl/hdlc_rxs_w1c_bank.sv
module hdlc_rxs_w1c_bank #(
   parameter int unsigned W    = 8,
   parameter int unsigned USED = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [USED-1:0] set_vec,
   input  logic            clr_en,
   input  logic [USED-1:0] clr_vec,
   output logic [W-1:0]    q
);
   if (USED > W || USED < 1) begin : g_bad_used
      $error("hdlc_rxs_w1c_bank: USED must lie in 1..W");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i < USED) begin : g_live
         logic b_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                     b_q <= 1'b0;
            else if (set_vec[i])            b_q <= 1'b1;
            else if (clr_en && clr_vec[i])  b_q <= 1'b0;
         end
         assign q[i] = b_q;
      end else begin : g_tie
         assign q[i] = 1'b0;
      end
   end
endmodule

// File: rtl/hdlc_rxs_irq_gen.sv
module hdlc_rxs_irq_gen #(
   parameter int unsigned W       = 8,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] status,
   input  logic [W-1:0] mask,
   output logic         irq
);
   logic pend;
   assign pend = |(status & mask);

   if (REG_OUT) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= pend;
      end
      assign irq = irq_q;
   end else begin : g_comb
      wire unused_clk_rst = clk ^ rst_n;
      assign irq = pend;
   end
endmodule

// File: rtl/hdlc_rx_status_latch.sv
module hdlc_rx_status_latch
   import hdlc_rxs_pkg::*;
#(
   parameter int unsigned W       = STAT_W,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ev_overrun,
   input  logic         ev_open_byte,
   input  logic         ev_pkt_start,
   input  logic         ev_pkt_end,
   input  logic         ev_crc_err,
   input  logic         ev_abort,
   input  logic         lvl_above_hwm,
   input  logic         lvl_not_empty,
   input  logic         wr_status_en,
   input  logic [W-1:0] wr_status_data,
   input  logic         wr_mask_en,
   input  logic [W-1:0] wr_mask_data,
   output logic [W-1:0] status_q,
   output logic [W-1:0] mask_q,
   output logic         irq
);
   localparam int unsigned SPARE = W - N_USED;

   if (W < N_USED) begin : g_bad_w
      $error("hdlc_rx_status_latch: W too small for the status layout");
   end

   logic [N_LVL-1:0]  lvl_vec;
   logic [N_LVL-1:0]  lvl_rise;
   logic [N_USED-1:0] set_vec;

   always_comb begin
      lvl_vec        = '0;
      lvl_vec[L_NE]  = lvl_not_empty;
      lvl_vec[L_HWM] = lvl_above_hwm;
   end

   hdlc_rxs_rise_det #(.W(N_LVL)) u_rise (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  (lvl_vec),
      .rise (lvl_rise)
   );

   // set sources; packet end merges normal end with every fault cause
   always_comb begin
      set_vec        = '0;
      set_vec[B_OVR] = ev_overrun;
      set_vec[B_OB]  = ev_open_byte;
      set_vec[B_PE]  = ev_pkt_end | ev_crc_err | ev_abort | ev_overrun;
      set_vec[B_PS]  = ev_pkt_start;
      set_vec[B_HWM] = lvl_rise[L_HWM];
      set_vec[B_NE]  = lvl_rise[L_NE];
   end

   hdlc_rxs_w1c_bank #(.W(W), .USED(N_USED)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_vec(set_vec),
      .clr_en (wr_status_en),
      .clr_vec(wr_status_data[N_USED-1:0]),
      .q      (status_q)
   );

   if (SPARE > 0) begin : g_spare
      wire unused_spare_clr = ^wr_status_data[W-1:N_USED];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          mask_q <= '0;
      else if (wr_mask_en) mask_q <= wr_mask_data;
   end

   hdlc_rxs_irq_gen #(.W(W), .REG_OUT(IRQ_REG)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .status(status_q),
      .mask  (mask_q),
      .irq   (irq)
   );
endmodule

// File: rtl/hdlc_rx_status_latch_chk.sv
module hdlc_rx_status_latch_chk #(
   parameter int unsigned W       = 8,
   parameter bit          IRQ_REG = 1'b0
) (
   input logic         clk,
   input logic         rst_n,
   input logic         ev_overrun,
   input logic         ev_open_byte,
   input logic         ev_pkt_start,
   input logic         ev_pkt_end,
   input logic         ev_crc_err,
   input logic         ev_abort,
   input logic         lvl_not_empty,
   input logic         wr_status_en,
   input logic [W-1:0] wr_status_data,
   input logic         wr_mask_en,
   input logic [W-1:0] wr_mask_data,
   input logic [W-1:0] status_q,
   input logic [W-1:0] mask_q,
   input logic         irq
);
   logic armed_q;
   always_ff @(posedge clk) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= 1'b1;
   end

   p_spare_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      status_q[W-1:6] == '0);

   p_ovr_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ev_overrun |=> status_q[5] && status_q[3]);

   p_open_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ev_open_byte |=> status_q[4]);

   p_end_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_pkt_end || ev_crc_err || ev_abort) |=> status_q[3]);

   // set beats a same-cycle clear (R5, R9)
   p_start_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ev_pkt_start |=> status_q[2]);

   p_ne_no_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q && lvl_not_empty && $past(lvl_not_empty) && !status_q[0] |=> !status_q[0]);

   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_status_en && wr_status_data[4] && !ev_open_byte |=> !status_q[4]);

   p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
      status_q[5] && !(wr_status_en && wr_status_data[5]) |=> status_q[5]);

   p_mask_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mask_en |=> mask_q == $past(wr_mask_data));

   if (!IRQ_REG) begin : g_irq_chk
      p_irq_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
         irq == (|(status_q & mask_q)));
   end
endmodule

bind hdlc_rx_status_latch hdlc_rx_status_latch_chk #(.W(W), .IRQ_REG(IRQ_REG)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .ev_overrun    (ev_overrun),
   .ev_open_byte  (ev_open_byte),
   .ev_pkt_start  (ev_pkt_start),
   .ev_pkt_end    (ev_pkt_end),
   .ev_crc_err    (ev_crc_err),
   .ev_abort      (ev_abort),
   .lvl_not_empty (lvl_not_empty),
   .wr_status_en  (wr_status_en),
   .wr_status_data(wr_status_data),
   .wr_mask_en    (wr_mask_en),
   .wr_mask_data  (wr_mask_data),
   .status_q      (status_q),
   .mask_q        (mask_q),
   .irq           (irq)
);

// File: tb/hdlc_rx_status_latch_tb.sv
`timescale 1ns/1ps
module hdlc_rx_status_latch_tb;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       ev_overrun, ev_open_byte, ev_pkt_start, ev_pkt_end, ev_crc_err, ev_abort;
   logic       lvl_above_hwm, lvl_not_empty;
   logic       wr_status_en, wr_mask_en;
   logic [7:0] wr_status_data, wr_mask_data;
   logic [7:0] status_q, mask_q;
   logic       irq;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   hdlc_rx_status_latch u_dut (
      .clk(clk), .rst_n(rst_n),
      .ev_overrun(ev_overrun), .ev_open_byte(ev_open_byte),
      .ev_pkt_start(ev_pkt_start), .ev_pkt_end(ev_pkt_end),
      .ev_crc_err(ev_crc_err), .ev_abort(ev_abort),
      .lvl_above_hwm(lvl_above_hwm), .lvl_not_empty(lvl_not_empty),
      .wr_status_en(wr_status_en), .wr_status_data(wr_status_data),
      .wr_mask_en(wr_mask_en), .wr_mask_data(wr_mask_data),
      .status_q(status_q), .mask_q(mask_q), .irq(irq)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one-cycle event pulse, bits: {ovr, ob, ps, pe, crc, abort}
   task automatic pulse(input logic [5:0] ev);
      {ev_overrun, ev_open_byte, ev_pkt_start, ev_pkt_end, ev_crc_err, ev_abort} = ev;
      @(negedge clk);
      {ev_overrun, ev_open_byte, ev_pkt_start, ev_pkt_end, ev_crc_err, ev_abort} = '0;
   endtask

   task automatic clr(input logic [7:0] pat);
      wr_status_en = 1'b1; wr_status_data = pat;
      @(negedge clk);
      wr_status_en = 1'b0; wr_status_data = '0;
   endtask

   task automatic set_mask(input logic [7:0] m);
      wr_mask_en = 1'b1; wr_mask_data = m;
      @(negedge clk);
      wr_mask_en = 1'b0; wr_mask_data = '0;
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      {ev_overrun, ev_open_byte, ev_pkt_start, ev_pkt_end, ev_crc_err, ev_abort} = '0;
      lvl_above_hwm = 0; lvl_not_empty = 0;
      wr_status_en = 0; wr_status_data = '0; wr_mask_en = 0; wr_mask_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset status", status_q, 8'h00);
      chk("R10 reset mask", mask_q, 8'h00);
      chk("R11 reset irq", {7'd0, irq}, 8'h00);
   endtask

   task automatic t_events;
      pulse(6'b100000); chk("R2 overrun sets bits 5 and 3", status_q, 8'h28);
      clr(8'hFF);       chk("R8 clear all", status_q, 8'h00);
      pulse(6'b010000); chk("R3 opening byte", status_q, 8'h10);
      clr(8'hFF);
      pulse(6'b001000); chk("R5 packet start", status_q, 8'h04);
      clr(8'hFF);
      pulse(6'b000100); chk("R4 normal end", status_q, 8'h08);
      clr(8'hFF);
      pulse(6'b000010); chk("R4 crc error", status_q, 8'h08);
      clr(8'hFF);
      pulse(6'b000001); chk("R4 abort", status_q, 8'h08);
      clr(8'hFF);
   endtask

   task automatic t_sticky_partial;
      pulse(6'b110000);
      repeat (5) @(negedge clk);
      chk("R12 bits hold while idle", status_q, 8'h38);
      clr(8'h00);   chk("R8 writing zeros changes nothing", status_q, 8'h38);
      clr(8'h20);   chk("R8 clear only bit 5", status_q, 8'h18);
      clr(8'hC8);   chk("R8 clear bit 3, spare bits ignored", status_q, 8'h10);
      clr(8'hFF);
   endtask

   task automatic t_levels;
      lvl_above_hwm = 1'b1;
      @(negedge clk); chk("R6 watermark rise", status_q, 8'h02);
      clr(8'h02);     chk("R6 clear while level high", status_q, 8'h00);
      repeat (3) @(negedge clk);
      chk("R6 held level does not re-set", status_q, 8'h00);
      lvl_above_hwm = 1'b0; @(negedge clk);
      lvl_above_hwm = 1'b1; @(negedge clk);
      chk("R6 second rise sets again", status_q, 8'h02);
      lvl_above_hwm = 1'b0;
      clr(8'hFF);
      lvl_not_empty = 1'b1;
      @(negedge clk); chk("R7 not-empty rise", status_q, 8'h01);
      clr(8'h01);     chk("R7 clear while level high", status_q, 8'h00);
      repeat (3) @(negedge clk);
      chk("R7 held level does not re-set", status_q, 8'h00);
      lvl_not_empty = 1'b0; @(negedge clk);
      lvl_not_empty = 1'b1; @(negedge clk);
      chk("R7 second rise sets again", status_q, 8'h01);
      lvl_not_empty = 1'b0;
      clr(8'hFF);
   endtask

   task automatic t_set_vs_clear;
      pulse(6'b001000);
      ev_pkt_start = 1'b1; wr_status_en = 1'b1; wr_status_data = 8'h04;
      @(negedge clk);
      ev_pkt_start = 1'b0; wr_status_en = 1'b0; wr_status_data = '0;
      chk("R9 set wins over clear", status_q, 8'h04);
      ev_pkt_end = 1'b1; wr_status_en = 1'b1; wr_status_data = 8'h04;
      @(negedge clk);
      ev_pkt_end = 1'b0; wr_status_en = 1'b0; wr_status_data = '0;
      chk("R9 other bit cleared while bit 3 sets", status_q, 8'h08);
      clr(8'hFF);
   endtask

   task automatic t_all_and_spare;
      lvl_above_hwm = 1'b1; lvl_not_empty = 1'b1;
      pulse(6'b111111);
      chk("R1 all sources, spare bits zero", status_q, 8'h3F);
      lvl_above_hwm = 1'b0; lvl_not_empty = 1'b0;
      clr(8'hFF);
      chk("R8 full clear", status_q, 8'h00);
   endtask

   task automatic t_mask;
      pulse(6'b001000);
      chk("R11 masked out, no irq", {7'd0, irq}, 8'h00);
      wr_mask_en = 1'b1; wr_mask_data = 8'h04;
      #5 chk("R11 irq unchanged before edge", {7'd0, irq}, 8'h00);
      @(negedge clk);
      wr_mask_en = 1'b0; wr_mask_data = '0;
      chk("R10 mask readback", mask_q, 8'h04);
      chk("R11 irq after mask write", {7'd0, irq}, 8'h01);
      set_mask(8'hFB);
      chk("R10 mask readback all bits", mask_q, 8'hFB);
      chk("R11 mask misses pending bit", {7'd0, irq}, 8'h00);
      set_mask(8'hFF);
      chk("R11 full mask", {7'd0, irq}, 8'h01);
      clr(8'h04);
      chk("R11 irq drops after clear", {7'd0, irq}, 8'h00);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_events();
      t_sticky_partial();
      t_levels();
      t_set_vs_clear();
      t_all_and_spare();
      t_mask();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule